// File: doc/BRIEF.md
# Tone burst generator sequencer

This block produces timed bursts of a digitally synthesized tone. A 32-bit phase accumulator, clocked by the tone clock, emits a step strobe each time it carries. A 7-bit step index advances once per strobe, so one tone period spans 128 steps. Each step turns the index into a signed 8-bit sample code, sine-weighted or square, and presents it with a one-cycle valid strobe. The sample stream feeds a downstream converter.

A register stage writes a 15-bit frequency word together with its precomputed accumulator increment, a 16-bit duration in millisecond ticks, and three mode bits: square output, a two-tone pattern, and the finish rule. A burst starts once both frequency and duration are nonzero. While a burst runs, new values can be queued. They take over at the end of the current burst without resetting the accumulator or the step index, and the busy flag stays high across the join. When the duration runs out, the tone keeps going to a clean end point: the next zero crossing, or the end of the current whole cycle.

Top module: `tone_burst_seq`

## Requirements
- R1: After reset, busy, sample and sample_vld are all 0.
- R2: A burst starts only when the stored frequency word and the stored duration are both nonzero. A duration written while the frequency is zero starts nothing until a nonzero frequency is written. busy rises within two clocks of the write that completes the pair.
- R3: Each carry out of the 32-bit phase accumulator (increment below 2^31) advances the step index by one, modulo 128. One cycle later, sample_vld pulses once with the sample of the new index. With an increment of 2^29, valid samples are 8 clocks apart.
- R4: In sine mode (mode_square=0), the sample for index s is round(127*sin(2*pi*s/128)) in two's complement. It is 0 at indices 0 and 64.
- R5: In square mode (mode_square=1), the sample is +127 for indices 0..63 and -127 for 64..127.
- R6: With mode_two_tone=1, cycles repeat in groups of three, starting at burst start. The first cycle uses the programmed increment. The next two use twice that increment, so samples come at half the spacing.
- R7: The duration counts ticks of MS_DIV tone clocks, starting at the beginning of the burst or of the queued burst.
- R8: After the duration expires, the burst ends on a strobe that brings the index to 0 or 64 when mode_fin_zero=1, and only to 0 when mode_fin_zero=0.
- R9: A frequency or nonzero duration written during a burst starts a follow-on burst at the end point. The follow-on burst does not clear the accumulator or the step index, and busy does not fall between the two bursts.
- R10: Writing a duration of 0 during a burst ends it at the next end point chosen by mode_fin_zero.
- R11: When a burst ends with nothing queued, busy falls and the stored duration becomes 0, so a later frequency write alone starts nothing. The frequency is kept, so a later duration write restarts with it.
- R12: A queued value written again before the follow-on burst begins is replaced. Only the last write is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freq_we | input | 1 | Write strobe for the frequency word and increment |
| freq_word | input | 15 | Tone frequency word; zero means unset |
| freq_inc | input | 32 | Accumulator increment matching freq_word |
| dur_we | input | 1 | Write strobe for the duration |
| dur_ms | input | 16 | Burst duration in millisecond ticks |
| mode_we | input | 1 | Write strobe for the mode bits |
| mode_square | input | 1 | 1 selects square output, 0 sine |
| mode_two_tone | input | 1 | 1 selects the one-then-two-at-double pattern |
| mode_fin_zero | input | 1 | 1 ends at a zero crossing, 0 at a whole cycle |
| busy | output | 1 | High while a burst or its follow-on runs |
| sample | output | 8 | Signed sample code |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |

## Verification
Some properties are checked on every cycle. The step index moves by exactly one per valid sample, and the accumulator wraps on each strobe. busy rises only from a complete frequency/duration pair, and every fall of busy lands on a legal end point with the duration cleared. Square samples sit at full scale, and the duration counter only holds or steps down. The bench scenarios cover what no single cycle can show: the exact sample sequence and spacing of whole bursts, the halved spacing of the two-tone pattern, the phase-continuous join of a queued burst, replacement of a queued duration, the early stop on a zero duration, and which stored values survive the end of a burst.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} tbs_state_e;
  localparam int STEP_W = 7;
  localparam int SAMP_W = 8;
endpackage

// File: rtl/tbs_phase_acc.sv
module tbs_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             dbl,
  input  logic [ACC_W-1:0] inc,
  output logic             strobe
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + (dbl ? {inc, 1'b0} : {1'b0, inc});
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = sum[ACC_W-1:0];
    strobe = en && !clr && sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R3: a carry always leaves the accumulator below its previous value
  p_wrap_on_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (acc_q < $past(acc_q)));
endmodule

// File: rtl/tbs_ms_timer.sv
module tbs_ms_timer #(
  parameter int DUR_W  = 16,
  parameter int MS_DIV = 27000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  input  logic             abort,
  output logic             expired
);
  localparam int PRE_W = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DUR_W-1:0] left_q, left_d;
  logic             tick;

  always_comb begin
    tick   = (pre_q == PRE_LAST);
    pre_d  = tick ? '0 : pre_q + 1'b1;
    left_d = left_q;
    if (tick && left_q != '0) left_d = left_q - 1'b1;
    if (load) begin
      pre_d  = '0;
      left_d = load_val;
    end
    if (abort) left_d = '0;
    expired = (left_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      left_q <= '0;
    end else begin
      pre_q  <= pre_d;
      left_q <= left_d;
    end
  end

  // R7: without a load, the remaining count only holds or drops by one
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !abort) |=> (left_q == $past(left_q) || left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/tbs_wave.sv
module tbs_wave
  import tbs_pkg::*;
(
  input  logic [STEP_W-1:0]        step,
  input  logic                     square,
  output logic signed [SAMP_W-1:0] sample
);
  function automatic logic [6:0] quarter(input logic [5:0] k);
    case (k)
      6'd0:  quarter = 7'd0;   6'd1:  quarter = 7'd6;   6'd2:  quarter = 7'd12;
      6'd3:  quarter = 7'd19;  6'd4:  quarter = 7'd25;  6'd5:  quarter = 7'd31;
      6'd6:  quarter = 7'd37;  6'd7:  quarter = 7'd43;  6'd8:  quarter = 7'd49;
      6'd9:  quarter = 7'd54;  6'd10: quarter = 7'd60;  6'd11: quarter = 7'd65;
      6'd12: quarter = 7'd71;  6'd13: quarter = 7'd76;  6'd14: quarter = 7'd81;
      6'd15: quarter = 7'd85;  6'd16: quarter = 7'd90;  6'd17: quarter = 7'd94;
      6'd18: quarter = 7'd98;  6'd19: quarter = 7'd102; 6'd20: quarter = 7'd106;
      6'd21: quarter = 7'd109; 6'd22: quarter = 7'd112; 6'd23: quarter = 7'd115;
      6'd24: quarter = 7'd117; 6'd25: quarter = 7'd120; 6'd26: quarter = 7'd122;
      6'd27: quarter = 7'd123; 6'd28: quarter = 7'd125; 6'd29: quarter = 7'd126;
      6'd30: quarter = 7'd126; 6'd31: quarter = 7'd127; default: quarter = 7'd127;
    endcase
  endfunction

  logic [5:0] idx;
  logic [6:0] mag;

  always_comb begin
    idx = step[5] ? (6'd32 - {1'b0, step[4:0]}) : {1'b0, step[4:0]};
    mag = quarter(idx);
    if (square) sample = step[6] ? -8'sd127 : 8'sd127;
    else        sample = step[6] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/tone_burst_seq.sv
module tone_burst_seq
  import tbs_pkg::*;
#(
  parameter int FREQ_W = 15,
  parameter int INC_W  = 32,
  parameter int DUR_W  = 16,
  parameter int MS_DIV = 27000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     freq_we,
  input  logic [FREQ_W-1:0]        freq_word,
  input  logic [INC_W-1:0]         freq_inc,
  input  logic                     dur_we,
  input  logic [DUR_W-1:0]         dur_ms,
  input  logic                     mode_we,
  input  logic                     mode_square,
  input  logic                     mode_two_tone,
  input  logic                     mode_fin_zero,
  output logic                     busy,
  output logic signed [SAMP_W-1:0] sample,
  output logic                     sample_vld
);
  localparam logic [STEP_W-1:0] HALF_STEP = STEP_W'(1 << (STEP_W - 1));

  logic [1:0] rsync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_l = rsync_q[1];

  tbs_state_e               st_q, st_d;
  logic [FREQ_W-1:0]        freq_q, freq_d;
  logic [INC_W-1:0]         inc_q, inc_d, act_q, act_d;
  logic [DUR_W-1:0]         dur_q, dur_d;
  logic                     pend_q, pend_d;
  logic                     sq_q, sq_d, tt_q, tt_d, fin_q, fin_d;
  logic [STEP_W-1:0]        step_q, step_d, step_nxt;
  logic [1:0]               seg_q, seg_d;
  logic signed [SAMP_W-1:0] samp_q, samp_d, wave;
  logic                     vld_q, vld_d;
  logic                     running, start, strobe, expired, at_end, finish, reload, stop, abort;

  always_comb begin
    running  = (st_q == ST_RUN);
    start    = !running && freq_q != '0 && dur_q != '0;
    step_nxt = step_q + 1'b1;
    at_end   = (step_nxt == '0) || (fin_q && step_nxt == HALF_STEP);
    finish   = running && strobe && expired && at_end;
    reload   = finish && pend_q && dur_q != '0 && freq_q != '0;
    stop     = finish && !reload;
    abort    = running && dur_we && dur_ms == '0;
  end

  tbs_phase_acc #(.ACC_W(INC_W)) u_acc (
    .clk(clk), .rst_n(rst_l), .clr(start), .en(running),
    .dbl(tt_q && seg_q != 2'd0), .inc(act_q), .strobe(strobe)
  );

  tbs_ms_timer #(.DUR_W(DUR_W), .MS_DIV(MS_DIV)) u_timer (
    .clk(clk), .rst_n(rst_l), .load(start || reload), .load_val(dur_q),
    .abort(abort), .expired(expired)
  );

  tbs_wave u_wave (.step(step_nxt), .square(sq_q), .sample(wave));

  always_comb begin
    st_d = st_q;   freq_d = freq_q; inc_d = inc_q; act_d = act_q;
    dur_d = dur_q; pend_d = pend_q; sq_d = sq_q;   tt_d = tt_q; fin_d = fin_q;
    step_d = step_q; seg_d = seg_q; samp_d = samp_q; vld_d = 1'b0;
    if (start) begin
      st_d = ST_RUN; act_d = inc_q; step_d = '0; seg_d = 2'd0; pend_d = 1'b0;
    end else if (!running) begin
      samp_d = '0;
    end
    if (running && strobe) begin
      step_d = step_nxt;
      samp_d = wave;
      vld_d  = 1'b1;
      if (step_nxt == '0) seg_d = (seg_q == 2'd2) ? 2'd0 : seg_q + 2'd1;
    end
    if (reload) begin
      act_d = inc_q; pend_d = 1'b0;
    end
    if (stop) begin
      st_d = ST_IDLE; dur_d = '0; pend_d = 1'b0;
    end
    if (freq_we) begin
      freq_d = freq_word; inc_d = freq_inc;
      if (running) pend_d = 1'b1;
    end
    if (dur_we) begin
      dur_d = dur_ms;
      if (running && dur_ms != '0) pend_d = 1'b1;
    end
    if (mode_we) begin
      sq_d = mode_square; tt_d = mode_two_tone; fin_d = mode_fin_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q <= ST_IDLE; freq_q <= '0; inc_q <= '0; act_q <= '0; dur_q <= '0;
      pend_q <= 1'b0;  sq_q <= 1'b0; tt_q <= 1'b0; fin_q <= 1'b0;
      step_q <= '0;    seg_q <= 2'd0; samp_q <= '0; vld_q <= 1'b0;
    end else begin
      st_q <= st_d; freq_q <= freq_d; inc_q <= inc_d; act_q <= act_d; dur_q <= dur_d;
      pend_q <= pend_d; sq_q <= sq_d; tt_q <= tt_d; fin_q <= fin_d;
      step_q <= step_d; seg_q <= seg_d; samp_q <= samp_d; vld_q <= vld_d;
    end
  end

  assign busy       = running;
  assign sample     = samp_q;
  assign sample_vld = vld_q;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_l)
    (!busy && !$past(busy)) |-> !sample_vld);
  p_start_pair_r2: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(busy) |-> ($past(freq_q) != '0 && $past(dur_q) != '0));
  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_l)
    sample_vld |-> (step_q == $past(step_q) + 1'b1));
  p_square_level_r5: assert property (@(posedge clk) disable iff (!rst_l)
    (sample_vld && $past(sq_q)) |-> (sample == 8'sd127 || sample == -8'sd127));
  p_end_point_r8: assert property (@(posedge clk) disable iff (!rst_l)
    $fell(busy) |-> (step_q == '0 || ($past(fin_q) && step_q == HALF_STEP)));
  p_dur_cleared_r11: assert property (@(posedge clk) disable iff (!rst_l)
    $fell(busy) |-> (dur_q == '0));
endmodule

// File: tb/test_tone_burst_seq.sv
module test_tone_burst_seq;
  localparam int MS_DIV = 64;
  localparam logic [31:0] INC8 = 32'h2000_0000;
  localparam logic [31:0] INC4 = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freq_we = 1'b0, dur_we = 1'b0, mode_we = 1'b0;
  logic [14:0] freq_word = '0;
  logic [31:0] freq_inc = '0;
  logic [15:0] dur_ms = '0;
  logic mode_square = 1'b0, mode_two_tone = 1'b0, mode_fin_zero = 1'b0;
  logic busy, sample_vld;
  logic signed [7:0] sample;

  int checks = 0;
  int errors = 0;
  int exp_val[$];
  int exp_gap[$];
  int gapcnt = 0;
  int falls = 0;
  logic busy_prev = 1'b0;

  always #5 clk = ~clk;

  tone_burst_seq #(.MS_DIV(MS_DIV)) i_tone_burst_seq (
    .clk(clk), .rst_n(rst_n), .freq_we(freq_we), .freq_word(freq_word), .freq_inc(freq_inc),
    .dur_we(dur_we), .dur_ms(dur_ms), .mode_we(mode_we), .mode_square(mode_square),
    .mode_two_tone(mode_two_tone), .mode_fin_zero(mode_fin_zero),
    .busy(busy), .sample(sample), .sample_vld(sample_vld)
  );

  function automatic int ref_wave(int s, bit sq);
    if (sq) return (s < 64) ? 127 : -127;
    return int'($floor(127.0 * $sin(6.283185307179586 * s / 128.0) + 0.5));
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push_burst(int first_step, int n, bit sq, int first_gap, int gap);
    for (int i = 0; i < n; i++) begin
      exp_val.push_back(ref_wave((first_step + i) % 128, sq));
      exp_gap.push_back(i == 0 ? first_gap : gap);
    end
  endtask

  task automatic wr_freq(int f, logic [31:0] inc);
    @(negedge clk); freq_we = 1'b1; freq_word = 15'(f); freq_inc = inc;
    @(negedge clk); freq_we = 1'b0;
  endtask

  task automatic wr_dur(int d);
    @(negedge clk); dur_we = 1'b1; dur_ms = 16'(d);
    @(negedge clk); dur_we = 1'b0;
  endtask

  task automatic wr_mode(bit sq, bit tt, bit fin);
    @(negedge clk); mode_we = 1'b1; mode_square = sq; mode_two_tone = tt; mode_fin_zero = fin;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wait_idle(string req);
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_val.size() == 0, req, exp_val.size(), 0);
    exp_val.delete();
    exp_gap.delete();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      busy_prev <= busy;
      if (busy_prev && !busy) falls++;
      gapcnt++;
      if (sample_vld) begin
        if (exp_val.size() == 0) begin
          chk(1'b0, "R3 unexpected sample", int'(sample), 0);
        end else begin
          int ev, eg;
          ev = exp_val.pop_front();
          eg = exp_gap.pop_front();
          chk(int'(sample) == ev, "R4/R5 sample value", int'(sample), ev);
          if (eg != 0) chk(gapcnt == eg, "R3/R6 sample spacing", gapcnt, eg);
        end
        gapcnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(sample == 8'sd0, "R1 sample", int'(sample), 0);
    chk(sample_vld == 1'b0, "R1 valid", int'(sample_vld), 0);

    // R2: duration alone does not start; frequency completes the pair
    wr_mode(1'b0, 1'b0, 1'b0);
    wr_dur(3);
    repeat (50) @(negedge clk);
    chk(busy == 1'b0, "R2 no start without frequency", int'(busy), 0);
    push_burst(1, 128, 1'b0, 0, 8);
    wr_freq(1000, INC8);
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R2 start after pair", int'(busy), 1);
    wait_idle("R8 whole-cycle end, sine R4");

    // R11: duration cleared, frequency kept; fin at zero crossing (R8)
    wr_freq(500, INC8);
    repeat (50) @(negedge clk);
    chk(busy == 1'b0, "R11 freq alone after stop", int'(busy), 0);
    wr_mode(1'b0, 1'b0, 1'b1);
    push_burst(1, 64, 1'b0, 0, 8);
    wr_dur(3);
    wait_idle("R11 restart with kept freq, R8 zero crossing");

    // R5 square, whole-cycle end
    wr_mode(1'b1, 1'b0, 1'b0);
    push_burst(1, 128, 1'b1, 0, 8);
    wr_dur(3);
    wait_idle("R5 square burst");

    // R9/R12: queued follow-on burst with new freq, duration overwritten
    wr_mode(1'b0, 1'b0, 1'b0);
    push_burst(1, 128, 1'b0, 0, 8);
    push_burst(1, 128, 1'b0, 0, 4);
    f0 = falls;
    wr_dur(3);
    repeat (20) @(negedge clk);
    wr_freq(700, INC4);
    wr_dur(9);
    wr_dur(2);
    wait_idle("R12 overwritten duration, R9 continuous join");
    chk(falls == f0 + 1, "R9 busy held across join", falls - f0, 1);

    // R6/R7: two-tone, 20 ms reaches into the double-rate cycle
    wr_mode(1'b0, 1'b1, 1'b0);
    wr_freq(1000, INC8);
    push_burst(1, 128, 1'b0, 0, 8);
    push_burst(1, 128, 1'b0, 4, 4);
    wr_dur(20);
    wait_idle("R6 two-tone pattern, R7 duration");

    // R10: zero duration aborts at next zero crossing
    wr_mode(1'b0, 1'b0, 1'b1);
    push_burst(1, 64, 1'b0, 0, 8);
    wr_dur(100);
    repeat (240) @(negedge clk);
    wr_dur(0);
    wait_idle("R10 abort on zero duration");
    wr_freq(1000, INC8);
    repeat (50) @(negedge clk);
    chk(busy == 1'b0, "R11 no restart after abort", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule